// File: doc/BRIEF.md
# Bus Phase and Strobe Timing Generator

This block turns one fast master clock into a slow processor-style bus clock (`phi2`) and a family of control strobes whose edges all fall on master-clock boundaries. A counter divides the master clock by `DIV` to form `phi2`, which is high for half of each bus cycle. A chain of registers then holds copies of `phi2` that are each one master clock later than the one before. Selected copies are combined and registered into active-low row and column strobes for a dynamic memory.

Every edge is counted in master clocks rather than set by gate or wire delay. The timing of each strobe within the bus cycle is therefore fixed by parameters and does not move when the surrounding logic gets faster or slower. A one-clock `cyc_start` pulse marks the start of each high phase of `phi2`, so other logic can align to the bus cycle.

Top module: `bus_phase_gen`

## Requirements
- R1: After reset is released, `phi2` stays low for `DIV/2` master clocks and then high for `DIV/2`, repeating with a period of `DIV` clocks.
- R2: Bit k of `phase_taps` equals `phi2` delayed by exactly k master clocks; bit 0 is `phi2` itself.
- R3: `ras_n` is active low and is driven low one master clock after tap `ROW_TAP` is high, returning high one clock after that tap falls.
- R4: `cas_n` is active low and is driven low one master clock after taps `ROW_TAP` and `COL_TAP` are both high, returning high one clock after either of them falls.
- R5: `cyc_start` is high for exactly one master clock per bus cycle: the first clock in which `phi2` is high.
- R6: While `rst` is high (synchronous, active high), `phi2`, every tap and `cyc_start` are low and both strobes are high. After release, no strobe goes low before the first rise of `phi2` plus `ROW_TAP + 1` clocks.
- R7: In each bus cycle `ras_n` makes one low pulse of `DIV/2` clocks and `cas_n` makes one low pulse of `DIV/2 - (COL_TAP - ROW_TAP)` clocks, nested inside the `ras_n` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| phi2 | output | 1 | Divided bus clock |
| phase_taps | output | NTAPS | Copies of phi2 delayed by 0..NTAPS-1 master clocks |
| cyc_start | output | 1 | One-clock pulse at the start of the phi2 high phase |
| ras_n | output | 1 | Registered active-low row strobe |
| cas_n | output | 1 | Registered active-low column strobe |

## Verification
The bench builds two copies of the block side by side. The first uses the default configuration: divide by 8, row tap 1 and column tap 3. The second uses divide by 6 with a six-stage chain, row tap 2 and column tap 4, which makes the column pulse only one clock wide. The second copy shows that the cycle length, the tap count and the strobe placement all follow the parameters and are not tied to the default values. It also covers the narrowest column pulse that is allowed, along with a reset asserted in the middle of a bus cycle.

// File: rtl/bus_phase_pkg.sv
package bus_phase_pkg;

   // Master clocks spent in one half of a bus cycle.
   function automatic int half_of(input int div);
      return div / 2;
   endfunction

   // Width of a counter that holds 0 .. div-1.
   function automatic int cnt_width(input int div);
      return (div > 2) ? $clog2(div) : 1;
   endfunction

   // Length in clocks of the column strobe pulse.
   function automatic int col_len(input int div, input int row, input int col);
      return half_of(div) - (col - row);
   endfunction

endpackage

// File: rtl/phase_divider.sv
module phase_divider
   import bus_phase_pkg::*;
#(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst,
   output logic phi2
);
   localparam int CW = cnt_width(DIV);
   localparam logic [CW-1:0] HALF_C = CW'(half_of(DIV));
   localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic          phi2_q;

   always_comb begin
      if (cnt_q == LAST_C) cnt_nx = '0;
      else                 cnt_nx = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         phi2_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nx;
         phi2_q <= (cnt_nx >= HALF_C);
      end
   end

   assign phi2 = phi2_q;

   // R1: phi2 may only change at the two phase boundaries of the count
   a_r1_edge_place: assert property (@(posedge clk) disable iff (rst)
      (phi2_q != $past(phi2_q)) |-> (cnt_q == '0 || cnt_q == HALF_C));

   // R1: the first clock after reset release begins a low phase
   a_r1_low_first: assert property (@(posedge clk)
      ($past(rst) && !rst) |-> !phi2_q);
endmodule

// File: rtl/phase_tap_chain.sv
module phase_tap_chain #(
   parameter int NTAPS = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             phi2,
   output logic [NTAPS-1:0] taps,
   output logic             cyc_start
);
   assign taps[0] = phi2;

   for (genvar k = 1; k < NTAPS; k++) begin : g_stage
      logic stage_q;
      always_ff @(posedge clk) begin
         if (rst) stage_q <= 1'b0;
         else     stage_q <= taps[k-1];
      end
      assign taps[k] = stage_q;

      // R2: each stage repeats its predecessor one clock later
      a_r2_shift: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (taps[k] == $past(taps[k-1])));
   end

   assign cyc_start = taps[0] & ~taps[1];

   // R5: the cycle-start pulse lasts a single clock and only while phi2 is high
   a_r5_single: assert property (@(posedge clk) disable iff (rst)
      cyc_start |=> !cyc_start);
   a_r5_in_high: assert property (@(posedge clk) disable iff (rst)
      cyc_start |-> phi2);
endmodule

// File: rtl/strobe_combiner.sv
module strobe_combiner (
   input  logic clk,
   input  logic rst,
   input  logic row_tap,
   input  logic col_tap,
   output logic ras_n,
   output logic cas_n
);
   logic ras_n_q;
   logic cas_n_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ras_n_q <= 1'b1;
         cas_n_q <= 1'b1;
      end else begin
         ras_n_q <= ~row_tap;
         cas_n_q <= ~(row_tap & col_tap);
      end
   end

   assign ras_n = ras_n_q;
   assign cas_n = cas_n_q;

   // R4: column strobe never active outside the row strobe
   a_r4_nested: assert property (@(posedge clk) disable iff (rst)
      !cas_n_q |-> !ras_n_q);
endmodule

// File: rtl/bus_phase_gen.sv
module bus_phase_gen
   import bus_phase_pkg::*;
#(
   parameter int DIV     = 8,
   parameter int NTAPS   = DIV,
   parameter int ROW_TAP = 1,
   parameter int COL_TAP = 3
) (
   input  logic             clk,
   input  logic             rst,
   output logic             phi2,
   output logic [NTAPS-1:0] phase_taps,
   output logic             cyc_start,
   output logic             ras_n,
   output logic             cas_n
);
   if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
      $error("DIV must be even and at least 4");
   end
   if (NTAPS < 2) begin : g_bad_ntaps
      $error("NTAPS must be at least 2");
   end
   if (ROW_TAP < 0 || COL_TAP <= ROW_TAP || COL_TAP >= NTAPS) begin : g_bad_taps
      $error("tap order must satisfy 0 <= ROW_TAP < COL_TAP < NTAPS");
   end
   if (col_len(DIV, ROW_TAP, COL_TAP) < 1) begin : g_bad_gap
      $error("COL_TAP - ROW_TAP must be less than DIV/2");
   end

   logic             phi2_w;
   logic [NTAPS-1:0] taps_w;
   logic             start_w;

   phase_divider #(.DIV(DIV)) u_div (
      .clk  (clk),
      .rst  (rst),
      .phi2 (phi2_w)
   );

   phase_tap_chain #(.NTAPS(NTAPS)) u_chain (
      .clk       (clk),
      .rst       (rst),
      .phi2      (phi2_w),
      .taps      (taps_w),
      .cyc_start (start_w)
   );

   strobe_combiner u_strb (
      .clk     (clk),
      .rst     (rst),
      .row_tap (taps_w[ROW_TAP]),
      .col_tap (taps_w[COL_TAP]),
      .ras_n   (ras_n),
      .cas_n   (cas_n)
   );

   assign phi2       = phi2_w;
   assign phase_taps = taps_w;
   assign cyc_start  = start_w;

   // R6: one clock after reset is seen, every output is idle
   a_r6_reset_idle: assert property (@(posedge clk)
      rst |=> (ras_n && cas_n && !phi2 && !cyc_start));
endmodule

// File: tb/bus_phase_gen_tb.sv
module bus_phase_gen_tb;
   localparam int A_DIV = 8, A_ROW = 1, A_COL = 3;
   localparam int B_DIV = 6, B_ROW = 2, B_COL = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic             a_phi2, a_cyc, a_ras, a_cas;
   logic [A_DIV-1:0] a_taps;
   logic             b_phi2, b_cyc, b_ras, b_cas;
   logic [B_DIV-1:0] b_taps;

   bus_phase_gen #(.DIV(A_DIV), .ROW_TAP(A_ROW), .COL_TAP(A_COL)) u_dut (
      .clk(clk), .rst(rst), .phi2(a_phi2), .phase_taps(a_taps),
      .cyc_start(a_cyc), .ras_n(a_ras), .cas_n(a_cas));

   bus_phase_gen #(.DIV(B_DIV), .ROW_TAP(B_ROW), .COL_TAP(B_COL)) u_dut_b (
      .clk(clk), .rst(rst), .phi2(b_phi2), .phase_taps(b_taps),
      .cyc_start(b_cyc), .ras_n(b_ras), .cas_n(b_cas));

   int checks = 0;
   int errors = 0;
   int n      = 0;

   function automatic bit ph(input int div, input int m);
      return (m >= 0) && ((m % div) >= div / 2);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s n=%0d actual %0d expected %0d", req, what, n, act, exp);
      end
   endtask

   task automatic check_one(input string tag, input int div, input int row, input int col,
                            input int ntaps, input logic [7:0] taps, input logic p,
                            input logic cs, input logic r, input logic c);
      string sreq;
      chk("R1", {tag, " phi2"}, int'(p), int'(ph(div, n)));
      for (int k = 0; k < ntaps; k++)
         chk("R2", $sformatf("%s tap%0d", tag, k), int'(taps[k]), int'(ph(div, n - k)));
      chk("R5", {tag, " cyc_start"}, int'(cs), int'(n >= 0 && (n % div) == div / 2));
      sreq = (n <= div / 2 + row) ? "R6" : "R3";
      chk(sreq, {tag, " ras_n"}, int'(r), int'(!ph(div, n - 1 - row)));
      sreq = (n <= div / 2 + row) ? "R6" : "R4";
      chk(sreq, {tag, " cas_n"}, int'(c),
          int'(!(ph(div, n - 1 - row) && ph(div, n - 1 - col))));
   endtask

   task automatic check_state();
      check_one("A", A_DIV, A_ROW, A_COL, A_DIV, 8'(a_taps), a_phi2, a_cyc, a_ras, a_cas);
      check_one("B", B_DIV, B_ROW, B_COL, B_DIV, 8'(b_taps), b_phi2, b_cyc, b_ras, b_cas);
   endtask

   task automatic check_idle(input string what);
      chk("R6", {what, " A phi2/taps/cyc"}, int'(a_phi2 | (|a_taps) | a_cyc), 0);
      chk("R6", {what, " A strobes"}, int'({a_ras, a_cas}), 3);
      chk("R6", {what, " B phi2/taps/cyc"}, int'(b_phi2 | (|b_taps) | b_cyc), 0);
      chk("R6", {what, " B strobes"}, int'({b_ras, b_cas}), 3);
   endtask

   task automatic step();
      @(posedge clk);
      n++;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("in reset");
      rst = 1'b0;
      n = 0;
      check_state();
   endtask

   task automatic t_sweep(input int steps);
      for (int i = 0; i < steps; i++) begin
         step();
         check_state();
      end
   endtask

   task automatic t_pulse_shape();
      int a_rl = 0, a_cl = 0, a_rf = 0, a_cf = 0;
      int b_rl = 0, b_cl = 0, b_rf = 0, b_cf = 0;
      logic pa_r = a_ras, pa_c = a_cas, pb_r = b_ras, pb_c = b_cas;
      for (int i = 0; i < A_DIV * B_DIV; i++) begin
         step();
         check_state();
         if (i < A_DIV) begin
            a_rl += int'(!a_ras); a_cl += int'(!a_cas);
            a_rf += int'(pa_r && !a_ras); a_cf += int'(pa_c && !a_cas);
         end
         if (i < B_DIV) begin
            b_rl += int'(!b_ras); b_cl += int'(!b_cas);
            b_rf += int'(pb_r && !b_ras); b_cf += int'(pb_c && !b_cas);
         end
         pa_r = a_ras; pa_c = a_cas; pb_r = b_ras; pb_c = b_cas;
      end
      chk("R7", "A ras low clocks", a_rl, A_DIV / 2);
      chk("R7", "A cas low clocks", a_cl, A_DIV / 2 - (A_COL - A_ROW));
      chk("R7", "A ras pulses", a_rf, 1);
      chk("R7", "A cas pulses", a_cf, 1);
      chk("R7", "B ras low clocks", b_rl, B_DIV / 2);
      chk("R7", "B cas low clocks", b_cl, B_DIV / 2 - (B_COL - B_ROW));
      chk("R7", "B ras pulses", b_rf, 1);
      chk("R7", "B cas pulses", b_cf, 1);
   endtask

   task automatic t_midrun_reset();
      t_sweep(A_DIV / 2 + A_ROW + 2);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_idle("mid-cycle reset");
      @(posedge clk);
      @(negedge clk);
      check_idle("held reset");
      rst = 1'b0;
      n = 0;
      check_state();
      t_sweep(2 * A_DIV * B_DIV);
   endtask

   initial begin
      t_reset_state();
      t_sweep(3 * A_DIV * B_DIV);
      t_pulse_shape();
      t_midrun_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule